// File: doc/BRIEF.md
# Clock-Synchronous Full-Duplex Serial Port

This block is an 8-bit clock-synchronous serial port with a small register bus. Software writes a byte to the data address to send it and reads the same address to collect a received byte. Each transfer moves one word in each direction at the same time. Bits go out least significant first. Outgoing data changes on the falling edge of the shift clock, and incoming data is sampled on the rising edge. The shift clock is made internally by dividing the system clock, or it is taken from an external clock input. When the clock is internal it is driven on `sclk_out` and `sclk_oe` is high.

The design centres on how the port enable, receive enable and transmit enable bits start, stop and initialise the two halves of the port.

- With an internal clock, the transmitter's clock generator is the only source of shift clocks. A transfer begins only when a byte is written to the transmit buffer, so receive-only work begins with a dummy write.
- While receive is enabled with an internal clock, clearing transmit enable does not reset the transmitter. Clearing the port enable bit never resets it either.
- The transmitter is a four-state machine (`gen_state_e`):
  - `GEN_IDLE` moves to `GEN_LOW` when a buffered byte starts with the internal clock.
  - `GEN_IDLE` moves to `GEN_EXT` when a buffered byte starts with the external clock.
  - `GEN_LOW` moves to `GEN_HIGH` when the divider expires (a rising edge).
  - `GEN_HIGH` moves back to `GEN_LOW` when the divider expires on any bit but the last (a falling edge).
  - `GEN_HIGH` moves to `GEN_IDLE` when the divider expires on the last bit.
  - `GEN_EXT` moves to `GEN_IDLE` on the eighth synchronised rising edge of the external clock.
  - A transmit initialisation sends every state to `GEN_IDLE`.

Top module: `syncser_port`

## Requirements
- R1: After reset, control (address 1), status (address 2) and divisor (address 3) read 0x00. `sclk_out` is 1 and `sclk_oe` is 1, because the internal clock is selected.
- R2: With the internal clock (control bit 0 = 0), every low phase of `sclk_out` lasts DIV+1 system clocks, where DIV is the value at address 3. Every high phase inside a transfer also lasts DIV+1 clocks. The line idles high.
- R3: A transfer shifts 8 bits, LSB first. `sdo` changes only while the shift clock is low, and the peer reads each bit at the rising edge.
- R4: Status bit 0 (transmit buffer empty) clears on a write to address 0 and sets when the byte moves to the shifter. Status bit 2 (shift complete) clears when shifting starts and sets after the 8th bit.
- R5: After the 8th sampled bit with reception active, the byte appears at address 0 and status bit 1 (receive full) sets. A read of address 0 clears status bit 1.
- R6: If a byte completes while status bit 1 is set, status bit 3 (overrun) sets and the buffered byte is kept.
- R7: Clearing control bit 5 (receive enable) or control bit 7 (port enable) zeroes the receive shifter and bit count, and clears status bits 1 and 3. Status bits 4 to 7 always read 0.
- R8: When control bit 4 (transmit enable) is 0 and the exception of R9 does not apply, the transmitter is held idle, pending data is dropped and data writes start nothing. Status bits 0 and 2 read 0 while bit 4 is 0, and both read 1 once it is set again.
- R9: With the internal clock and control bit 5 = 1, clearing control bit 4 does not stop a running transfer. A data write then starts a receive-only transfer.
- R10: Clearing control bit 7 alone does not stop a transfer already in progress.
- R11: With the external clock (control bit 0 = 1), `sclk_oe` is 0. The port shifts on synchronised edges of `sclk_in` and sends and receives a full byte per 8 rising edges.
- R12: With the external clock, clearing control bit 4 zeroes the receive shifter only if `sclk_in` is high at that time.
- R13: A buffered byte starts a transfer only while control bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 status, 3 divisor |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 0 clears receive full) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| sclk_in | input | 1 | External shift clock |

## Verification
The bench builds the port with its defaults: an 8-bit word and a two-stage clock synchroniser. With those values it can sweep the divisor over 0 to 3 with several data patterns and measure every clock phase exactly. The external clock edges can be spaced well beyond the synchroniser delay, so the bit order and the data seen on `sdo` during each high phase are fully determined. The small divisors keep a transfer short enough to switch enable bits part-way through a transfer and observe whether the transfer continues.

// File: rtl/syncser_pkg.sv
package syncser_pkg;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_LOW  = 2'd1,
        GEN_HIGH = 2'd2,
        GEN_EXT  = 2'd3
    } gen_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    localparam int CB_PORT   = 7;
    localparam int CB_RX     = 5;
    localparam int CB_TX     = 4;
    localparam int CB_EXTCLK = 0;

    localparam int SB_TBE = 0;
    localparam int SB_RBF = 1;
    localparam int SB_TSC = 2;
    localparam int SB_OVR = 3;

endpackage

// File: rtl/syncser_edge.sv
module syncser_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[STAGES-1:0], pin_in};
        end
    end

    assign level = sync_q[STAGES-1];
    assign rise  = sync_q[STAGES-1] & ~sync_q[STAGES];
    assign fall  = ~sync_q[STAGES-1] & sync_q[STAGES];

endmodule

// File: rtl/syncser_regs.sv
module syncser_regs
    import syncser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load_ack,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_buf,
    input  logic              rx_full,
    input  logic              rx_ovr,
    output logic              port_en,
    output logic              rx_en,
    output logic              tx_en,
    output logic              ext_clk,
    output logic              init_tx,
    output logic              init_rx,
    output logic [DATA_W-1:0] div_val,
    output logic [DATA_W-1:0] tx_buf,
    output logic              tx_valid,
    output logic              rd_data_pulse
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] div_q;
    logic [DATA_W-1:0] txbuf_q;
    logic              valid_q;
    logic [DATA_W-1:0] status;
    logic              data_wr;

    assign data_wr = bus_wr && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            txbuf_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_DATA: txbuf_q <= bus_wdata;
                ADDR_CTRL: ctrl_q  <= bus_wdata;
                ADDR_DIV:  div_q   <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Buffer occupancy: a new write wins over the handoff to the shifter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (init_tx) begin
            valid_q <= 1'b0;
        end else if (data_wr) begin
            valid_q <= 1'b1;
        end else if (load_ack) begin
            valid_q <= 1'b0;
        end
    end

    assign port_en = ctrl_q[CB_PORT];
    assign rx_en   = ctrl_q[CB_RX];
    assign tx_en   = ctrl_q[CB_TX];
    assign ext_clk = ctrl_q[CB_EXTCLK];

    // The internal clock is shared with reception, so receive enable keeps
    // the transmit side alive when transmit enable is cleared.
    assign init_tx = ~tx_en & ~(~ext_clk & rx_en);
    assign init_rx = ~rx_en | ~port_en;

    assign div_val       = div_q;
    assign tx_buf        = txbuf_q;
    assign tx_valid      = valid_q;
    assign rd_data_pulse = bus_rd && (bus_addr == ADDR_DATA);

    always_comb begin
        status         = '0;
        status[SB_TBE] = tx_en & ~valid_q;
        status[SB_RBF] = rx_full;
        status[SB_TSC] = tx_en & ~busy;
        status[SB_OVR] = rx_ovr;
    end

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = rx_buf;
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = status;
            default:   bus_rdata = div_q;
        endcase
    end

    AST_TX_FLAGS_ON_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && $past(init_tx)) |-> (status[SB_TBE] && status[SB_TSC])); // R8

endmodule

// File: rtl/syncser_txgen.sv
module syncser_txgen
    import syncser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              port_en,
    input  logic              init_tx,
    input  logic [DATA_W-1:0] div_val,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_buf,
    input  logic              ext_rise,
    input  logic              ext_fall,
    output logic              load_ack,
    output logic              busy,
    output logic              int_sample,
    output logic              sclk_out,
    output logic              sdo
);
    localparam int              CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    gen_state_e        state_q;
    gen_state_e        state_d;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] tsh_q;
    logic [CNT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              start;
    logic              phase_end;

    assign phase_end = (cnt_q == '0);
    assign start     = (state_q == GEN_IDLE) && tx_valid && port_en && !init_tx;

    always_comb begin
        state_d = state_q;
        if (init_tx) begin
            state_d = GEN_IDLE;
        end else begin
            unique case (state_q)
                GEN_IDLE: if (start) state_d = ext_clk ? GEN_EXT : GEN_LOW;
                GEN_LOW:  if (phase_end) state_d = GEN_HIGH;
                GEN_HIGH: if (phase_end) state_d = (bit_q == LAST_BIT) ? GEN_IDLE : GEN_LOW;
                GEN_EXT:  if (ext_rise && bit_q == LAST_BIT) state_d = GEN_IDLE;
                default:  state_d = GEN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tsh_q  <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b1;
        end else if (init_tx) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b1;
        end else begin
            unique case (state_q)
                GEN_IDLE: begin
                    sclk_q <= 1'b1;
                    if (start) begin
                        tsh_q  <= tx_buf;
                        bit_q  <= '0;
                        cnt_q  <= div_val;
                        sclk_q <= ext_clk;
                    end
                end
                GEN_LOW: begin
                    if (phase_end) begin
                        cnt_q  <= div_val;
                        sclk_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                GEN_HIGH: begin
                    if (phase_end) begin
                        cnt_q <= div_val;
                        if (bit_q != LAST_BIT) begin
                            sclk_q <= 1'b0;
                            bit_q  <= bit_q + 1'b1;
                            tsh_q  <= tsh_q >> 1;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                GEN_EXT: begin
                    if (ext_fall && bit_q != '0) begin
                        tsh_q <= tsh_q >> 1;
                    end
                    if (ext_rise) begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign load_ack   = start;
    assign busy       = (state_q != GEN_IDLE);
    assign int_sample = (state_q == GEN_LOW) && phase_end && !init_tx;
    assign sclk_out   = sclk_q;
    assign sdo        = tsh_q[0];

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_IDLE) |-> sclk_q); // R2
    AST_TX_INIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        init_tx |=> (state_q == GEN_IDLE)); // R8
    AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_IDLE && !port_en) |=> (state_q == GEN_IDLE)); // R13

endmodule

// File: rtl/syncser_rx.sv
module syncser_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_rx,
    input  logic              clr_shift,
    input  logic              sample,
    input  logic              sdi,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rx_full,
    output logic              rx_ovr
);
    localparam int              CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] rsh_q;
    logic [DATA_W-1:0] buf_q;
    logic [DATA_W-1:0] next_word;
    logic [CNT_W-1:0]  rcnt_q;
    logic              full_q;
    logic              ovr_q;
    logic              byte_done;

    assign next_word = {sdi, rsh_q[DATA_W-1:1]};
    assign byte_done = sample && !clr_shift && (rcnt_q == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsh_q  <= '0;
            rcnt_q <= '0;
            buf_q  <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (init_rx) begin
            rsh_q  <= '0;
            rcnt_q <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (clr_shift) begin
                rsh_q  <= '0;
                rcnt_q <= '0;
            end else if (sample) begin
                rsh_q  <= next_word;
                rcnt_q <= (rcnt_q == LAST_BIT) ? '0 : rcnt_q + 1'b1;
            end
            if (byte_done && full_q) begin
                ovr_q <= 1'b1;
            end
            if (byte_done && !full_q) begin
                buf_q  <= next_word;
                full_q <= 1'b1;
            end else if (rd_clr) begin
                full_q <= 1'b0;
            end
        end
    end

    assign rx_buf  = buf_q;
    assign rx_full = full_q;
    assign rx_ovr  = ovr_q;

    AST_RX_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_rx |=> (!full_q && !ovr_q && rsh_q == '0 && rcnt_q == '0)); // R7
    AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $stable(buf_q)); // R6
    AST_FULL_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> $past(sample)); // R5

endmodule

// File: rtl/syncser_port.sv
module syncser_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sdo,
    input  logic              sdi,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sclk_in
);
    logic              port_en;
    logic              rx_en;
    logic              tx_en;
    logic              ext_clk;
    logic              init_tx;
    logic              init_rx;
    logic [DATA_W-1:0] div_val;
    logic [DATA_W-1:0] tx_buf;
    logic              tx_valid;
    logic              rd_data_pulse;
    logic              load_ack;
    logic              busy;
    logic              int_sample;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_full;
    logic              rx_ovr;
    logic              ext_level;
    logic              ext_rise;
    logic              ext_fall;
    logic              rx_sample;
    logic              rx_clr_shift;

    syncser_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .load_ack(load_ack), .busy(busy),
        .rx_buf(rx_buf), .rx_full(rx_full), .rx_ovr(rx_ovr),
        .port_en(port_en), .rx_en(rx_en), .tx_en(tx_en), .ext_clk(ext_clk),
        .init_tx(init_tx), .init_rx(init_rx),
        .div_val(div_val), .tx_buf(tx_buf), .tx_valid(tx_valid),
        .rd_data_pulse(rd_data_pulse)
    );

    syncser_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(sclk_in),
        .level(ext_level), .rise(ext_rise), .fall(ext_fall)
    );

    syncser_txgen #(.DATA_W(DATA_W)) u_txgen (
        .clk(clk), .rst_n(rst_n),
        .ext_clk(ext_clk), .port_en(port_en), .init_tx(init_tx),
        .div_val(div_val), .tx_valid(tx_valid), .tx_buf(tx_buf),
        .ext_rise(ext_rise), .ext_fall(ext_fall),
        .load_ack(load_ack), .busy(busy), .int_sample(int_sample),
        .sclk_out(sclk_out), .sdo(sdo)
    );

    assign rx_sample    = ext_clk ? ext_rise : int_sample;
    assign rx_clr_shift = init_tx & (~ext_clk | ext_level);

    syncser_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .init_rx(init_rx), .clr_shift(rx_clr_shift),
        .sample(rx_sample), .sdi(sdi), .rd_clr(rd_data_pulse),
        .rx_buf(rx_buf), .rx_full(rx_full), .rx_ovr(rx_ovr)
    );

    assign sclk_oe = ~ext_clk;

    AST_RX_IGNORES_IDLE_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (init_rx && !rx_full) |=> !rx_full); // R5
    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clk |-> !sclk_oe); // R11

endmodule

// File: tb/syncser_port_bench.sv
module syncser_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sdo;
    logic       sclk_out;
    logic       sclk_oe;
    logic       sclk_in = 1'b1;
    logic       tb_sdi = 1'b0;
    logic       loop = 1'b1;
    logic       sdi;

    int checks = 0, errors = 0, mon_checks = 0, mon_errors = 0;
    int cur_div = 0;
    int mon_frames = 0;
    int mon_bits = 0;
    int run_len = 0;
    logic [7:0] mon_byte = 8'h00;
    logic [7:0] mon_last = 8'h00;
    logic prev_sclk = 1'b1;
    logic prev_sdo = 1'b0;

    assign sdi = loop ? sdo : tb_sdi;

    always #(CLK_PERIOD/2) clk = ~clk;

    syncser_port u_syncser_port (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sdo(sdo), .sdi(sdi),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sclk_in(sclk_in)
    );

    // Line monitor for the internally generated clock
    always @(negedge clk) begin
        if (rst_n && sclk_oe) begin
            if (sclk_out == prev_sclk) begin
                run_len++;
                if (sclk_out && prev_sclk && sdo !== prev_sdo) begin
                    mon_checks++; mon_errors++;
                    $display("FAIL R3: sdo changed while clock high, actual %0b expected %0b", sdo, prev_sdo);
                end
            end else begin
                if (!prev_sclk || (mon_bits > 0 && mon_bits < 8)) begin
                    mon_checks++;
                    if (run_len != cur_div + 1) begin
                        mon_errors++;
                        $display("FAIL R2: phase length actual %0d expected %0d", run_len, cur_div + 1);
                    end
                end
                if (sclk_out) begin
                    mon_byte[mon_bits] = sdo;
                    mon_bits++;
                    if (mon_bits == 8) begin
                        mon_last = mon_byte;
                        mon_frames++;
                        mon_bits = 0;
                    end
                end
                run_len = 1;
            end
        end else begin
            run_len = 1;
        end
        prev_sclk = sclk_out;
        prev_sdo = sdo;
    end

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_wait();
        idle(16 * (cur_div + 1) + 8);
    endtask

    task automatic ext_bit(input logic b, output logic so);
        @(negedge clk);
        sclk_in = 1'b0; tb_sdi = b;
        idle(6);
        sclk_in = 1'b1;
        idle(6);
        so = sdo;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] got;
        logic so;
        int f0;

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        bus_read(2'd1, v); check8("R1 ctrl", v, 8'h00);
        bus_read(2'd2, v); check8("R1 status", v, 8'h00);
        bus_read(2'd3, v); check8("R1 divisor", v, 8'h00);
        check8("R1 sclk_out", {7'd0, sclk_out}, 8'h01);
        check8("R1 sclk_oe", {7'd0, sclk_oe}, 8'h01);

        bus_write(2'd1, 8'hB0);
        bus_read(2'd2, v); check8("R8 flags after enable", v, 8'h05);

        // R2 R3 R4 R5: divisor and data sweep in loopback
        for (int dv = 0; dv < 4; dv++) begin
            bus_write(2'd3, 8'(dv));
            cur_div = dv;
            bus_read(2'd3, v); check8("R2 divisor readback", v, 8'(dv));
            for (int k = 0; k < 4; k++) begin
                logic [7:0] d;
                d = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : 8'((dv * 4 + k) * 53 + 7);
                f0 = mon_frames;
                bus_write(2'd0, d);
                bus_read(2'd2, v); check8("R4 shifting status", v, 8'h01);
                frame_wait();
                check8("R3 frame count", 8'(mon_frames - f0), 8'h01);
                check8("R3 LSB-first line data", mon_last, d);
                bus_read(2'd2, v); check8("R5 status after frame", v, 8'h07);
                bus_read(2'd0, v); check8("R5 received byte", v, d);
                bus_read(2'd2, v); check8("R5 full cleared by read", v, 8'h05);
            end
        end

        // R6 overrun, R7 clears
        bus_write(2'd3, 8'd0); cur_div = 0;
        bus_write(2'd0, 8'h11); frame_wait();
        bus_write(2'd0, 8'h22); frame_wait();
        bus_read(2'd2, v); check8("R6 overrun status", v, 8'h0F);
        bus_read(2'd0, v); check8("R6 old byte kept", v, 8'h11);
        bus_read(2'd2, v); check8("R6 overrun persists", v, 8'h0D);
        bus_write(2'd1, 8'h90);
        bus_read(2'd2, v); check8("R7 rx disable clears", v, 8'h05);
        bus_write(2'd1, 8'hB0);
        bus_write(2'd0, 8'h33); frame_wait();
        bus_write(2'd1, 8'h30);
        bus_read(2'd2, v); check8("R7 port disable clears", v, 8'h05);

        // R9: tx disabled mid-frame with rx enabled, internal clock
        bus_write(2'd1, 8'hB0);
        bus_write(2'd3, 8'd3); cur_div = 3;
        f0 = mon_frames;
        bus_write(2'd0, 8'h5A);
        idle(10);
        bus_write(2'd1, 8'hA0);
        bus_read(2'd2, v); check8("R8 flags read 0 while tx off", v, 8'h00);
        frame_wait();
        check8("R9 frame continued", 8'(mon_frames - f0), 8'h01);
        bus_read(2'd2, v); check8("R9 rx full", v, 8'h02);
        bus_read(2'd0, v); check8("R9 received", v, 8'h5A);

        // R9: receive-only via dummy write
        f0 = mon_frames;
        bus_write(2'd0, 8'hC3);
        frame_wait();
        check8("R9 dummy write started frame", 8'(mon_frames - f0), 8'h01);
        bus_read(2'd0, v); check8("R9 receive-only byte", v, 8'hC3);

        // R10: port disable mid-frame keeps transmitting
        bus_write(2'd1, 8'hB0);
        f0 = mon_frames;
        bus_write(2'd0, 8'h96);
        idle(10);
        bus_write(2'd1, 8'h30);
        frame_wait();
        check8("R10 frame completed", 8'(mon_frames - f0), 8'h01);
        check8("R10 frame data", mon_last, 8'h96);
        bus_read(2'd2, v); check8("R10 status", v, 8'h05);

        // R8: fully disabled transmitter ignores writes
        bus_write(2'd1, 8'h80);
        f0 = mon_frames;
        bus_write(2'd0, 8'h77);
        frame_wait();
        check8("R8 no frame while held", 8'(mon_frames - f0), 8'h00);
        check8("R8 clock idle", {7'd0, sclk_out}, 8'h01);
        bus_write(2'd1, 8'h90);
        bus_read(2'd2, v); check8("R8 flags back on re-enable", v, 8'h05);
        frame_wait();
        check8("R8 dropped write stays dropped", 8'(mon_frames - f0), 8'h00);

        // R13: no start without port enable
        bus_write(2'd1, 8'h30);
        f0 = mon_frames;
        bus_write(2'd0, 8'h44);
        frame_wait();
        check8("R13 no frame with port off", 8'(mon_frames - f0), 8'h00);
        bus_write(2'd1, 8'hB0);
        frame_wait();
        check8("R13 frame after port on", 8'(mon_frames - f0), 8'h01);
        bus_read(2'd0, v); check8("R13 byte", v, 8'h44);

        // R11: external clock
        loop = 1'b0;
        bus_write(2'd1, 8'hB1);
        check8("R11 clock not driven", {7'd0, sclk_oe}, 8'h00);
        bus_write(2'd0, 8'hE7);
        got = 8'h00;
        for (int i = 0; i < 8; i++) begin
            ext_bit(((8'h4B >> i) & 8'h01) != 0, so);
            got[i] = so;
        end
        idle(4);
        check8("R11 sdo bits", got, 8'hE7);
        bus_read(2'd2, v); check8("R11 status", v, 8'h07);
        bus_read(2'd0, v); check8("R11 received", v, 8'h4B);

        // R12: tx disable with external clock high clears rx shifter
        for (int i = 0; i < 3; i++) ext_bit(1'b1, so);
        bus_write(2'd1, 8'hA1);
        bus_write(2'd1, 8'hB1);
        for (int i = 0; i < 8; i++) ext_bit(i < 4, so);
        idle(4);
        bus_read(2'd2, v); check8("R12 high: full", v & 8'h02, 8'h02);
        bus_read(2'd0, v); check8("R12 high: shifter restarted", v, 8'h0F);

        // R12: with external clock low, shifter is kept
        for (int i = 0; i < 3; i++) ext_bit(1'b1, so);
        @(negedge clk);
        sclk_in = 1'b0; tb_sdi = 1'b1;
        idle(6);
        bus_write(2'd1, 8'hA1);
        bus_write(2'd1, 8'hB1);
        idle(2);
        sclk_in = 1'b1;
        idle(6);
        for (int i = 0; i < 4; i++) ext_bit(1'b0, so);
        idle(4);
        bus_read(2'd2, v); check8("R12 low: full", v & 8'h02, 8'h02);
        bus_read(2'd0, v); check8("R12 low: shifter kept", v, 8'h0F);

        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errors + mon_errors);
        $finish;
    end

endmodule